// File: doc/BRIEF.md
# Hash Job Sequencer

This block is the control sequencer of a message-digest execution unit. One job at a time, it takes a 12-bit mode word, a key length and an ICV byte count. It registers them and then checks the mode word. A valid job runs through a fixed series of phases. First it either seeds the digest with the algorithm's initial values or loads a saved intermediate context. Next it streams message blocks. Unless the job continues into a later one, it then pads and finalises. Optionally it ends by comparing the finished digest byte by byte against ICV bytes taken from the input FIFO.

The hash arithmetic lives in an external compression core. The sequencer talks to it through one request/command/acknowledge handshake and gets back a 512-bit digest. Every job ends with a one-cycle done pulse. A rejected mode word or an ICV mismatch leaves a sticky error code that drives a level interrupt until software clears it.

Top module: `hash_job_seq`

## Requirements
- R1: After reset the block is idle: busy, done, core request, FIFO read, digest valid and interrupt are all low, and the error code is 0.
- R2: The mode word layout is as follows. Bit 11 selects the layout and must be 1. Bit 10 is continue, bit 9 is compare-ICV, bit 8 is SSL-MAC, bit 7 is init and bit 6 is HMAC. Bits 5:3 are the algorithm code with bit 5 as the extended bit. Bits 2:0 are reserved and must be 0. A layout bit of 0 or any reserved bit set is a mode error.
- R3: Algorithm codes 0 to 3 are valid. The digest length in bytes for codes 0, 1, 2 and 3 is 20, 32, 16 and 28 (variant A) or 48, 32, 64 and 28 (variant B). Codes 4 to 7 are a mode error.
- R4: HMAC and SSL-MAC set together is a mode error. Either one set with a key length of 0 is also a mode error.
- R5: The first core command of a valid job is 1 (load initial values) when init is 1 and 2 (load context) when init is 0.
- R6: For each available message block the block issues command 3, holding the request until the acknowledge. The block flagged last ends the data phase.
- R7: With continue set, the job ends after its last block, with no pad or finalise command and no digest valid pulse.
- R8: With continue clear, command 4 (pad) is followed by command 5 (finalise). The digest is captured on the finalise acknowledge and appears on the digest output with a one-cycle valid pulse in the next cycle.
- R9: With compare-ICV set, the block reads exactly ICV-size bytes from the FIFO, at most one per cycle and only when the FIFO is not empty. Read k is compared with digest byte k, taken most significant first: bits 8*(L-1-k)+7 down to 8*(L-1-k) for a digest of L bytes. Any mismatch gives error code 2.
- R10: With compare-ICV set, an ICV size of 0, an ICV size above the digest length, or continue also set is a mode error.
- R11: On a mode error the job ends with error code 1. It issues no core command and no FIFO read. Every job ends with done high for exactly one cycle, and busy is high from acceptance to done.
- R12: The error code and the interrupt hold until the clear input. A job error that lands in the same cycle as a clear wins, and its code remains.
- R13: A job start presented while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| job_valid_i | input | 1 | Start a job (taken when idle) |
| job_mode_i | input | 12 | Mode word |
| key_len_i | input | KEYLEN_W | Key length for keyed MACs |
| icv_size_i | input | 7 | ICV bytes to compare |
| msg_avail_i | input | 1 | A message block is ready |
| msg_last_i | input | 1 | The ready block is the last of the job |
| core_req_o | output | 1 | Request to the compression core |
| core_cmd_o | output | 3 | Command: 1 init, 2 context, 3 block, 4 pad, 5 finalise |
| core_ack_i | input | 1 | Core accepts the request |
| core_digest_i | input | 512 | Digest from the core, right-aligned |
| digest_o | output | 512 | Captured digest |
| digest_valid_o | output | 1 | One-cycle digest strobe |
| fifo_rd_o | output | 1 | Input FIFO read |
| fifo_empty_i | input | 1 | Input FIFO empty |
| fifo_data_i | input | 8 | Input FIFO byte |
| done_o | output | 1 | One-cycle end-of-job pulse |
| busy_o | output | 1 | Job in progress |
| err_code_o | output | 2 | Sticky error: 0 none, 1 mode, 2 ICV |
| irq_o | output | 1 | Level interrupt while an error is held |
| err_clr_i | input | 1 | Clear the sticky error |

## Verification
Two events can land in one cycle: a job's error being recorded into the sticky status, and a software clear. The bench raises the clear in exactly the cycle in which it sees done, which is the cycle where the job's error is written. It does this both after an ICV mismatch and after a clean job. Judged one cycle later, the mismatch job must keep code 2 and the clean job must leave code 0. Random jobs add more such collisions, and those are judged against the bench's own model of the sticky code.

// File: rtl/hjs_pkg.sv
package hjs_pkg;
  localparam int MODE_W   = 12;
  localparam int MAXDIG_B = 64;
  localparam int DIG_W    = 8 * MAXDIG_B;
  localparam int ICV_W    = $clog2(MAXDIG_B) + 1;
  localparam int ALG_W    = 3;

  typedef enum logic [2:0] {
    CMD_NONE = 3'd0, CMD_IV = 3'd1, CMD_CTX = 3'd2,
    CMD_BLK  = 3'd3, CMD_PAD = 3'd4, CMD_FIN = 3'd5
  } core_cmd_e;

  typedef enum logic [1:0] {
    ERR_NONE = 2'd0, ERR_MODE = 2'd1, ERR_ICV = 2'd2
  } err_e;

  typedef struct packed {
    logic             fmt_new;
    logic             cont;
    logic             cicv;
    logic             smac;
    logic             init;
    logic             hmac;
    logic [ALG_W-1:0] alg;
    logic [2:0]       rsvd;
  } mode_t;

  // digest length in bytes; 0 marks a reserved code
  function automatic logic [ICV_W-1:0] dig_bytes(input logic [ALG_W-1:0] alg, input bit vb);
    case (alg)
      3'd0:    return vb ? ICV_W'(48) : ICV_W'(20);
      3'd1:    return ICV_W'(32);
      3'd2:    return vb ? ICV_W'(64) : ICV_W'(16);
      3'd3:    return ICV_W'(28);
      default: return '0;
    endcase
  endfunction

  // byte k of an L-byte right-aligned digest, most significant first
  function automatic logic [7:0] dig_byte(input logic [DIG_W-1:0] d,
                                          input logic [ICV_W-1:0] len,
                                          input logic [ICV_W-1:0] k);
    logic [DIG_W-1:0] sh;
    logic [9:0]       pos;
    pos = 10'(len) - 10'(k) - 10'd1;
    sh  = d >> {pos, 3'b000};
    return sh[7:0];
  endfunction
endpackage

// File: rtl/hjs_mode_check.sv
module hjs_mode_check
  import hjs_pkg::*;
#(
  parameter bit VARIANT_B = 1'b0,
  parameter int KEYLEN_W  = 8
) (
  input  logic [MODE_W-1:0]   mode_i,
  input  logic [KEYLEN_W-1:0] klen_i,
  input  logic [ICV_W-1:0]    isz_i,
  output logic [ICV_W-1:0]    dlen_o,
  output logic                mode_err_o
);
  mode_t m;
  logic  fmt_bad, alg_bad, mac_bad, icv_bad;

  assign m = mode_t'(mode_i);

  always_comb begin
    dlen_o     = dig_bytes(m.alg, VARIANT_B);
    fmt_bad    = !m.fmt_new || (m.rsvd != 3'b000);
    alg_bad    = (dlen_o == '0);
    mac_bad    = (m.hmac && m.smac) || ((m.hmac || m.smac) && (klen_i == '0));
    icv_bad    = m.cicv && ((isz_i == '0) || (isz_i > dlen_o) || m.cont);
    mode_err_o = fmt_bad || alg_bad || mac_bad || icv_bad;
  end
endmodule

// File: rtl/hjs_icv_cmp.sv
module hjs_icv_cmp
  import hjs_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             step_i,
  input  logic [7:0]       rx_i,
  input  logic [7:0]       exp_i,
  output logic [ICV_W-1:0] idx_o,
  output logic             mism_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_o  <= '0;
      mism_o <= 1'b0;
    end else if (clear_i) begin
      idx_o  <= '0;
      mism_o <= 1'b0;
    end else if (step_i) begin
      idx_o  <= idx_o + 1'b1;
      mism_o <= mism_o | (rx_i != exp_i);
    end
  end

  assert_mism_on_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mism_o) |-> $past(step_i))
    else $error("mismatch flag rose without a FIFO read");
endmodule

// File: rtl/hash_job_seq.sv
module hash_job_seq
  import hjs_pkg::*;
#(
  parameter bit VARIANT_B = 1'b0,
  parameter int KEYLEN_W  = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                job_valid_i,
  input  logic [11:0]         job_mode_i,
  input  logic [KEYLEN_W-1:0] key_len_i,
  input  logic [6:0]          icv_size_i,
  input  logic                msg_avail_i,
  input  logic                msg_last_i,
  output logic                core_req_o,
  output logic [2:0]          core_cmd_o,
  input  logic                core_ack_i,
  input  logic [511:0]        core_digest_i,
  output logic [511:0]        digest_o,
  output logic                digest_valid_o,
  output logic                fifo_rd_o,
  input  logic                fifo_empty_i,
  input  logic [7:0]          fifo_data_i,
  output logic                done_o,
  output logic                busy_o,
  output logic [1:0]          err_code_o,
  output logic                irq_o,
  input  logic                err_clr_i
);
  typedef enum logic [2:0] {
    S_IDLE, S_CHECK, S_SETUP, S_DATA, S_PAD, S_FIN, S_ICV, S_DONE
  } st_e;

  st_e              st;
  mode_t            mode_q;
  logic [KEYLEN_W-1:0] klen_q;
  logic [ICV_W-1:0] isz_q;
  logic [DIG_W-1:0] dig_q;
  logic             dval_q;
  logic             merr_q;
  err_e             err_q;
  core_cmd_e        cmd;

  logic [ICV_W-1:0] dlen, icv_idx;
  logic             mode_err, mism;

  // named events for the assertions
  logic hs, icv_last, err_set, icv_clear;
  err_e job_err;
  logic [7:0] exp_byte;

  hjs_mode_check #(.VARIANT_B(VARIANT_B), .KEYLEN_W(KEYLEN_W)) u_check (
    .mode_i(mode_q), .klen_i(klen_q), .isz_i(isz_q),
    .dlen_o(dlen), .mode_err_o(mode_err)
  );

  assign exp_byte  = dig_byte(dig_q, dlen, icv_idx);
  assign icv_clear = (st == S_CHECK);

  hjs_icv_cmp u_icv (
    .clk(clk), .rst_n(rst_n), .clear_i(icv_clear), .step_i(fifo_rd_o),
    .rx_i(fifo_data_i), .exp_i(exp_byte), .idx_o(icv_idx), .mism_o(mism)
  );

  always_comb begin
    case (st)
      S_SETUP: cmd = mode_q.init ? CMD_IV : CMD_CTX;
      S_DATA:  cmd = CMD_BLK;
      S_PAD:   cmd = CMD_PAD;
      S_FIN:   cmd = CMD_FIN;
      default: cmd = CMD_NONE;
    endcase
  end

  assign core_req_o = (st == S_SETUP) || (st == S_PAD) || (st == S_FIN) ||
                      ((st == S_DATA) && msg_avail_i);
  assign core_cmd_o = cmd;
  assign hs         = core_req_o && core_ack_i;
  assign fifo_rd_o  = (st == S_ICV) && !fifo_empty_i;
  assign icv_last   = fifo_rd_o && (icv_idx == isz_q - 1'b1);
  assign job_err    = merr_q ? ERR_MODE : (mism ? ERR_ICV : ERR_NONE);
  assign err_set    = (st == S_DONE) && (job_err != ERR_NONE);

  assign done_o         = (st == S_DONE);
  assign busy_o         = (st != S_IDLE);
  assign err_code_o     = err_q;
  assign irq_o          = (err_q != ERR_NONE);
  assign digest_o       = dig_q;
  assign digest_valid_o = dval_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      mode_q <= '0;
      klen_q <= '0;
      isz_q  <= '0;
      dig_q  <= '0;
      dval_q <= 1'b0;
      merr_q <= 1'b0;
    end else begin
      dval_q <= 1'b0;
      case (st)
        S_IDLE: if (job_valid_i) begin
          mode_q <= mode_t'(job_mode_i);
          klen_q <= key_len_i;
          isz_q  <= icv_size_i;
          merr_q <= 1'b0;
          st     <= S_CHECK;
        end
        S_CHECK: begin
          merr_q <= mode_err;
          st     <= mode_err ? S_DONE : S_SETUP;
        end
        S_SETUP: if (hs) st <= S_DATA;
        S_DATA: if (hs && msg_last_i) st <= mode_q.cont ? S_DONE : S_PAD;
        S_PAD:  if (hs) st <= S_FIN;
        S_FIN: if (hs) begin
          dig_q  <= core_digest_i;
          dval_q <= 1'b1;
          st     <= mode_q.cicv ? S_ICV : S_DONE;
        end
        S_ICV:  if (icv_last) st <= S_DONE;
        default: st <= S_IDLE;
      endcase
    end
  end

  // sticky error: a new job error wins over a clear in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          err_q <= ERR_NONE;
    else if (err_set)    err_q <= job_err;
    else if (err_clr_i)  err_q <= ERR_NONE;
  end

  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o) else $error("done longer than one cycle");

  assert_merr_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_CHECK && mode_err) |=> (done_o && !core_req_o && !fifo_rd_o))
    else $error("mode error did not end the job quietly");

  assert_known_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SETUP) |-> (dlen != '0)) else $error("reserved algorithm reached setup");

  assert_no_pad_on_cont_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (core_req_o && (core_cmd_o == CMD_PAD || core_cmd_o == CMD_FIN)) |-> !mode_q.cont)
    else $error("pad or finalise on a continued job");

  assert_dval_after_fin_R8: assert property (@(posedge clk) disable iff (!rst_n)
    digest_valid_o |-> $past(hs && core_cmd_o == CMD_FIN))
    else $error("digest valid without finalise handshake");

  assert_set_wins_R12: assert property (@(posedge clk) disable iff (!rst_n)
    err_set |=> (err_code_o == $past(job_err))) else $error("job error lost");

  assert_clear_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (err_clr_i && !err_set) |=> (err_code_o == ERR_NONE)) else $error("clear ignored");

  assert_rd_in_icv_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_rd_o |-> (mode_q.cicv && !merr_q && !fifo_empty_i))
    else $error("FIFO read outside an ICV check");
endmodule

// File: tb/test_hash_job_seq.sv
module test_hash_job_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic job_valid = 1'b0;
  logic [11:0] job_mode = '0;
  logic [7:0] key_len = '0;
  logic [6:0] icv_size = '0;
  logic msg_avail = 1'b0, msg_last = 1'b0;
  logic core_req, core_ack = 1'b0;
  logic [2:0] core_cmd;
  logic [511:0] core_digest = '0, digest;
  logic digest_valid, fifo_rd, fifo_empty = 1'b1;
  logic [7:0] fifo_data = '0;
  logic done, busy, irq, err_clr = 1'b0;
  logic [1:0] err_code;

  int total = 0, bad = 0;
  int sticky = 0;

  always #2 clk = ~clk;

  hash_job_seq i_hash_job_seq (
    .clk(clk), .rst_n(rst_n), .job_valid_i(job_valid), .job_mode_i(job_mode),
    .key_len_i(key_len), .icv_size_i(icv_size), .msg_avail_i(msg_avail),
    .msg_last_i(msg_last), .core_req_o(core_req), .core_cmd_o(core_cmd),
    .core_ack_i(core_ack), .core_digest_i(core_digest), .digest_o(digest),
    .digest_valid_o(digest_valid), .fifo_rd_o(fifo_rd), .fifo_empty_i(fifo_empty),
    .fifo_data_i(fifo_data), .done_o(done), .busy_o(busy), .err_code_o(err_code),
    .irq_o(irq), .err_clr_i(err_clr)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [11:0] mk(bit fnew, bit cont, bit cicv, bit smac,
                                     bit init, bit hmac, logic [2:0] alg, logic [2:0] rsv);
    return {fnew, cont, cicv, smac, init, hmac, alg, rsv};
  endfunction

  function automatic int len_of(logic [2:0] alg);
    case (alg)
      3'd0: return 20;
      3'd1: return 32;
      3'd2: return 16;
      3'd3: return 28;
      default: return 0;
    endcase
  endfunction

  function automatic bit bad_mode(logic [11:0] m, int klen, int isz);
    int L;
    L = len_of(m[5:3]);
    if (!m[11] || m[2:0] != 0 || L == 0) return 1;
    if (m[6] && m[8]) return 1;
    if ((m[6] || m[8]) && klen == 0) return 1;
    if (m[9] && (isz == 0 || isz > L || m[10])) return 1;
    return 0;
  endfunction

  function automatic int cmd_at(int i, bit init, int nblk);
    if (i == 0) return init ? 1 : 2;
    if (i <= nblk) return 3;
    if (i == nblk + 1) return 4;
    return 5;
  endfunction

  task automatic run_job(input logic [11:0] m, input int klen, input int isz,
                         input int nblk, input int corrupt, input bit inject,
                         input bit clr_at_done, input string tag);
    logic [511:0] dig;
    bit merr, cont, cicv;
    int L, ncmd, nrd, ndv, blk, cyc, exp_err, exp_cmds, pend_cmd;
    bit pend_ack, pend_rd, fin;
    for (int w = 0; w < 16; w++) dig[32*w +: 32] = $urandom;
    merr = bad_mode(m, klen, isz);
    cont = m[10]; cicv = m[9];
    L = len_of(m[5:3]);
    exp_err = merr ? 1 : ((cicv && corrupt >= 0 && corrupt < isz) ? 2 : 0);
    exp_cmds = merr ? 0 : (1 + nblk + (cont ? 0 : 2));
    core_digest = dig;
    @(negedge clk);
    job_mode = m; key_len = 8'(klen); icv_size = 7'(isz); job_valid = 1'b1;
    ncmd = 0; nrd = 0; ndv = 0; blk = 0; cyc = 0; pend_ack = 0; pend_rd = 0; fin = 0;
    pend_cmd = 0;
    while (!fin && cyc < 3000) begin
      @(negedge clk);
      cyc++;
      job_valid = inject && (cyc == 4);
      if (inject && cyc == 4) job_mode = 12'h000;
      if (pend_ack) begin
        if (pend_cmd == 3) blk++;
        core_ack = 1'b0; pend_ack = 0;
      end
      if (pend_rd) begin nrd++; pend_rd = 0; end
      msg_avail = ($urandom % 4) != 0;
      msg_last  = (blk == nblk - 1);
      fifo_empty = ($urandom % 3) == 0;
      fifo_data = (L > 0 && nrd < L) ? dig[8*(L-1-nrd) +: 8] : 8'h00;
      if (nrd == corrupt) fifo_data = fifo_data ^ 8'h5a;
      #1;
      if (core_req && ($urandom % 2) == 1) begin
        core_ack = 1'b1; pend_ack = 1; pend_cmd = int'(core_cmd);
        // R5 R6 R8 command order
        chk(pend_cmd == cmd_at(ncmd, m[7], nblk) && ncmd < exp_cmds, "R5/R6/R8",
            {tag, " command"}, pend_cmd, cmd_at(ncmd, m[7], nblk));
        ncmd++;
      end
      if (fifo_rd) pend_rd = 1;
      if (digest_valid) begin
        ndv++;
        chk(digest == dig, "R8", {tag, " digest low word"}, digest[63:0], dig[63:0]);
      end
      if (done) begin
        fin = 1;
        chk(busy, "R11", {tag, " busy at done"}, busy, 1);
        if (clr_at_done) err_clr = 1'b1;
      end
    end
    if (!fin) chk(0, "R11", {tag, " job never finished"}, cyc, 0);
    @(negedge clk);
    err_clr = 1'b0; core_ack = 1'b0; msg_avail = 1'b0; fifo_empty = 1'b1;
    if (pend_rd) nrd++;
    if (exp_err != 0) sticky = exp_err;
    else if (clr_at_done) sticky = 0;
    #1;
    chk(err_code == 2'(sticky), "R12", {tag, " error code"}, err_code, sticky);
    chk(irq == (sticky != 0), "R12", {tag, " irq"}, irq, sticky != 0);
    chk(!done && !busy, "R11", {tag, " done one cycle"}, {done, busy}, 0);
    chk(ncmd == exp_cmds, merr ? "R11" : "R6/R7", {tag, " command count"}, ncmd, exp_cmds);
    chk(nrd == ((cicv && !merr) ? isz : 0), "R9", {tag, " ICV reads"}, nrd,
        (cicv && !merr) ? isz : 0);
    chk(ndv == ((!merr && !cont) ? 1 : 0), "R7/R8", {tag, " digest pulses"}, ndv,
        (!merr && !cont) ? 1 : 0);
    if (inject) begin
      repeat (6) begin
        @(negedge clk); #1;
        chk(!done && !busy, "R13", {tag, " start while busy ignored"}, {done, busy}, 0);
      end
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    #1;
    // R1 reset state
    chk(!busy && !done && !core_req && !fifo_rd && !digest_valid && !irq && err_code == 0,
        "R1", "outputs during reset", {busy, done, core_req, fifo_rd, irq, err_code}, 0);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk(!busy && !done && !core_req && err_code == 0, "R1", "idle after reset",
        {busy, done, core_req, err_code}, 0);

    run_job(mk(1,0,0,0,1,0,3'd1,3'd0), 0, 0, 1, -1, 0, 0, "R5 R8 init sha256");
    run_job(mk(1,1,0,0,0,0,3'd0,3'd0), 0, 0, 3, -1, 0, 0, "R5 R7 ctx cont");
    run_job(mk(1,0,0,0,1,0,3'd5,3'd0), 0, 0, 1, -1, 0, 0, "R3 reserved alg");
    run_job(mk(0,0,0,0,1,0,3'd1,3'd0), 0, 0, 1, -1, 0, 1, "R2 layout bit");
    run_job(mk(1,0,0,0,1,0,3'd1,3'd4), 0, 0, 1, -1, 0, 1, "R2 reserved bits");
    run_job(mk(1,0,0,1,1,1,3'd2,3'd0), 16, 0, 1, -1, 0, 1, "R4 both macs");
    run_job(mk(1,0,0,0,1,1,3'd2,3'd0), 0, 0, 1, -1, 0, 1, "R4 zero key");
    run_job(mk(1,0,0,1,1,0,3'd3,3'd0), 16, 0, 2, -1, 0, 1, "R4 ssl mac ok");
    run_job(mk(1,0,1,0,1,1,3'd0,3'd0), 20, 20, 2, -1, 0, 0, "R9 icv match");
    run_job(mk(1,0,1,0,1,0,3'd1,3'd0), 0, 12, 1, 11, 0, 0, "R9 mismatch last");
    run_job(mk(1,0,1,0,1,0,3'd2,3'd0), 0, 16, 1, 0, 0, 1, "R12 set wins clear");
    run_job(mk(1,0,0,0,1,0,3'd1,3'd0), 0, 0, 1, -1, 0, 1, "R12 clear at done");
    run_job(mk(1,0,1,0,1,0,3'd1,3'd0), 0, 0, 1, -1, 0, 1, "R10 size zero");
    run_job(mk(1,0,1,0,1,0,3'd3,3'd0), 0, 29, 1, -1, 0, 1, "R10 size too big");
    run_job(mk(1,1,1,0,1,0,3'd3,3'd0), 0, 8, 1, -1, 0, 1, "R10 icv with cont");
    run_job(mk(1,0,1,0,0,0,3'd2,3'd0), 0, 16, 1, -1, 0, 0, "R10 size equals len");
    run_job(mk(1,0,0,0,1,0,3'd1,3'd0), 0, 0, 4, -1, 1, 0, "R13 busy start");

    for (int j = 0; j < 150; j++) begin
      logic [11:0] m;
      int klen, isz, nb, cor;
      m = mk(($urandom % 16) != 0, ($urandom % 3) == 0, ($urandom % 2) == 1,
             ($urandom % 4) == 0, ($urandom % 4) != 0, ($urandom % 3) == 0,
             ($urandom % 6 == 0) ? 3'($urandom % 8) : 3'($urandom % 4),
             ($urandom % 16 == 0) ? 3'd2 : 3'd0);
      klen = ($urandom % 5 == 0) ? 0 : 1 + ($urandom % 64);
      isz = $urandom % 34;
      nb = 1 + ($urandom % 4);
      cor = ($urandom % 3 == 0) ? int'($urandom % 34) : -1;
      run_job(m, klen, isz, nb, cor, 0, ($urandom % 4) == 0, "random job");
    end

    // R12 clear while idle
    @(negedge clk); err_clr = 1'b1;
    @(negedge clk); err_clr = 1'b0; #1;
    chk(err_code == 0 && !irq, "R12", "clear while idle", err_code, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule